// File: doc/BRIEF.md
# Page Buffer Load Controller

This block is the write side of a byte-wide nonvolatile memory model. A command decoder upstream decides when byte loads are allowed and signals this on `load_en`. Each qualified write strobe then places one byte into a page buffer of 2^SLOT_W slots. The low address bits pick the slot and the high address bits pick the page. A cycle counter measures the quiet time after each load. The next load must start within the window, or the load phase closes.

When the quiet time reaches `GAP_CYCLES`, the controller raises `busy` for `PROG_CYCLES` clocks. At the end of that time it writes the whole buffered page into the behavioural array in one step. The target page comes from the most recent accepted load. Slots that received no byte in this phase are written as FFh. The address and data of the last accepted load are held on output ports for status logic, such as polling of the inverted data bit or a toggle bit. The array can be read back through a separate combinational port.

Both time constants are counted in clock cycles. A full-size device uses a 17-bit address with 1024 pages of 128 bytes. The default here is a smaller array, chosen so that elaboration stays small.

Top module: `pgbuf_load_ctrl`

## Requirements
- R1: After reset `busy` is 0, `last_addr` and `last_data` are 0, and every array byte reads FFh.
- R2: A load is accepted once per strobe: on the first clock where cs_n=0, we_n=0, oe_n=1 and load_en=1 all hold together. If oe_n=0, or cs_n=1, or we_n=1, or load_en=0, nothing is loaded.
- R3: If no further load starts, `busy` rises exactly GAP_CYCLES clocks after the clock that accepted the last load.
- R4: A load accepted GAP_CYCLES-1 clocks after the previous one keeps the load phase open and restarts the quiet-time count.
- R5: A second load to a slot that is already filled replaces that slot's data.
- R6: Address bits [SLOT_W-1:0] select the slot and bits [ADDR_W-1:SLOT_W] select the page. The page of the last accepted load is the one written.
- R7: Slots not loaded during the phase are written as FFh. Pages other than the target page keep their contents.
- R8: `busy` stays high for exactly PROG_CYCLES clocks. The committed page is readable on `rd_data` in the first cycle after `busy` falls.
- R9: Loads presented while `busy` is high are ignored. They do not change the buffer, `last_addr`, `last_data`, or the timing of the cycle in progress.
- R10: `last_addr` and `last_data` show the address and data of the most recent accepted load.
- R11: When a commit finishes, all slot-filled flags are cleared. The next phase writes FFh into slots that were loaded only in earlier phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; blocks loads when low |
| load_en | input | 1 | Load permission from the command decoder |
| addr | input | ADDR_W | Byte address of the load |
| wdata | input | DATA_W | Byte to load |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte at `rd_addr` |
| busy | output | 1 | High during the internal program cycle |
| last_addr | output | ADDR_W | Address of the last accepted load |
| last_data | output | DATA_W | Data of the last accepted load |

## Verification
Suppose the quiet-time counter or the state is wrong. `busy` then rises or falls a cycle early or late, and the bench checks for this on the exact cycle. Suppose a slot flag or the page register is wrong. This shows up only after the commit: the first read of the page after `busy` falls returns a stale byte, a loaded byte where FFh belongs, or data in the wrong page. Wrongly accepting a load during `busy` is seen at once on `last_addr`, and again in the page that is committed next.

// File: rtl/pgbuf_load_ctrl.sv
module pgbuf_load_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SLOT_W      = 7,
  parameter int GAP_CYCLES  = 20000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data
);

  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int NBYTES = 1 << ADDR_W;
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} st_t;

  st_t               state;
  logic              qual, qual_q, load_go;
  logic [GAP_W-1:0]  gap_cnt;
  logic [PROG_W-1:0] prog_cnt;
  logic [SLOTS-1:0]  filled;
  logic [PAGE_W-1:0] tgt_page;
  logic [DATA_W-1:0] page_buf [SLOTS];
  logic [DATA_W-1:0] mem [NBYTES];

  wire [SLOT_W-1:0] slot    = addr[SLOT_W-1:0];
  wire              gap_end = (gap_cnt == GAP_W'(GAP_CYCLES - 1));
  wire              prog_end = (prog_cnt == PROG_W'(PROG_CYCLES - 1));

  assign qual    = !cs_n && !we_n && oe_n && load_en;
  assign load_go = qual && !qual_q && (state != ST_PROG);
  assign busy    = (state == ST_PROG);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end

  always_ff @(posedge clk) begin
    if (load_go) page_buf[slot] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gap_cnt   <= '0;
      prog_cnt  <= '0;
      filled    <= '0;
      tgt_page  <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_LOAD: begin
          if (load_go) begin
            state        <= ST_LOAD;
            gap_cnt      <= '0;
            filled[slot] <= 1'b1;
            tgt_page     <= addr[ADDR_W-1:SLOT_W];
            last_addr    <= addr;
            last_data    <= wdata;
          end else if (state == ST_LOAD) begin
            if (gap_end) begin
              state    <= ST_PROG;
              gap_cnt  <= '0;
              prog_cnt <= '0;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (prog_end) begin
            state  <= ST_IDLE;
            filled <= '0;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '1;
    end else if (busy && prog_end) begin
      for (int i = 0; i < SLOTS; i++)
        mem[{tgt_page, SLOT_W'(i)}] <= filled[i] ? page_buf[i] : '1;
    end
  end

  AST_LOAD_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_addr) |-> $past(!cs_n && !we_n && oe_n && load_en)); // R2
  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt < GAP_W'(GAP_CYCLES)); // R3
  AST_BUSY_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> filled != '0); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prog_cnt) == PROG_W'(PROG_CYCLES - 1)); // R8
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(last_addr) && $stable(last_data)); // R9
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> filled == '0); // R11

endmodule

// File: tb/pgbuf_load_ctrl_tb_top.sv
module pgbuf_load_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, DW = 8, SW = 7;
  localparam int GAP = 12, PROG = 20;
  localparam int SLOTS = 1 << SW, NB = 1 << AW, NPAGES = 1 << (AW - SW);

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, oe_n = 1, load_en = 1;
  logic [AW-1:0] addr = '0, rd_addr = '0, last_addr;
  logic [DW-1:0] wdata = '0, rd_data, last_data;
  logic busy;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] m_mem [NB];
  logic [DW-1:0] m_buf [SLOTS];
  bit            m_val [SLOTS];
  int            m_page;
  logic [AW-1:0] m_la;
  logic [DW-1:0] m_ld;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgbuf_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SLOT_W(SW),
    .GAP_CYCLES(GAP), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .load_en(load_en), .addr(addr), .wdata(wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .last_addr(last_addr), .last_data(last_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int page, int slot);
    return AW'(page * SLOTS + slot);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe active for one cycle; returns one negedge after the accepting edge
  task automatic strobe(logic [AW-1:0] a, logic [DW-1:0] d, bit accept);
    @(negedge clk);
    cs_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; we_n = 1;
    if (accept) begin
      m_buf[a[SW-1:0]] = d;
      m_val[a[SW-1:0]] = 1;
      m_page = int'(a[AW-1:SW]);
      m_la = a; m_ld = d;
    end
  endtask

  function automatic void model_commit();
    for (int i = 0; i < SLOTS; i++) begin
      m_mem[m_page * SLOTS + i] = m_val[i] ? m_buf[i] : 8'hFF;
      m_val[i] = 0;
    end
  endfunction

  task automatic rd_chk(string req, int a);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, m_mem[a]);
  endtask

  task automatic check_page(string req, int page);
    for (int i = 0; i < SLOTS; i++) rd_chk(req, page * SLOTS + i);
  endtask

  task automatic wait_commit();
    int n = 0;
    while (!busy && n < GAP + 4) begin @(negedge clk); n++; end
    chk("R3 busy reached", busy, 1);
    n = 0;
    while (busy && n < PROG + 4) begin @(negedge clk); n++; end
    chk("R8 busy ended", busy, 0);
    model_commit();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < SLOTS; i++) m_val[i] = 0;
    m_la = '0; m_ld = '0; m_page = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 last_addr", last_addr, 0);
    chk("R1 last_data", last_data, 0);
    rd_chk("R1 array", 0);
    rd_chk("R1 array", NB - 1);

    // R3 R8 exact timing, R10 status
    strobe(mk(2, 5), 8'h3C, 1);
    chk("R10 last_addr", last_addr, m_la);
    chk("R10 last_data", last_data, m_ld);
    idle(GAP - 1);
    chk("R3 busy before timeout", busy, 0);
    idle(1);
    chk("R3 busy at timeout", busy, 1);
    idle(PROG - 1);
    chk("R8 busy last cycle", busy, 1);
    idle(1);
    chk("R8 busy low", busy, 0);
    model_commit();
    check_page("R7 R8 page", 2);
    rd_chk("R7 other page", mk(3, 5));

    // R4 load at the last cycle of the window, R5 overwrite, R6 last page wins
    strobe(mk(4, 10), 8'h11, 1);
    idle(GAP - 2);
    strobe(mk(4, 10), 8'h22, 1);
    idle(GAP - 2);
    strobe(mk(6, 20), 8'h33, 1);
    idle(GAP - 1);
    chk("R4 window reset", busy, 0);
    idle(1);
    chk("R4 busy after final gap", busy, 1);
    wait_commit();
    check_page("R5 R6 page6", 6);
    check_page("R6 page4 untouched", 4);

    // R2 blocked strobes
    oe_n = 0; strobe(mk(1, 1), 8'hAA, 0); oe_n = 1;
    load_en = 0; strobe(mk(1, 2), 8'hAB, 0); load_en = 1;
    @(negedge clk); cs_n = 0; addr = mk(1, 3); wdata = 8'hAC;
    @(negedge clk); cs_n = 1;
    @(negedge clk); we_n = 0; addr = mk(1, 4);
    @(negedge clk); we_n = 1;
    idle(GAP + 3);
    chk("R2 no busy from blocked strobes", busy, 0);
    chk("R2 last_addr unchanged", last_addr, m_la);
    // R2 a held strobe counts once
    @(negedge clk); cs_n = 0; we_n = 0; addr = mk(1, 7); wdata = 8'h5A;
    m_buf[7] = 8'h5A; m_val[7] = 1; m_page = 1; m_la = mk(1, 7); m_ld = 8'h5A;
    idle(GAP + 1);
    chk("R2 held strobe one load", busy, 1);
    cs_n = 1; we_n = 1;
    // R9 loads while busy
    strobe(mk(7, 9), 8'h99, 0);
    chk("R9 last_addr", last_addr, m_la);
    chk("R9 last_data", last_data, m_ld);
    wait_commit();
    check_page("R9 page1", 1);
    check_page("R9 page7 untouched", 7);

    // R11 flags cleared: new phase on page1 with one slot
    strobe(mk(1, 100), 8'h01, 1);
    wait_commit();
    check_page("R11 page1 refresh", 1);

    // random phases
    for (int t = 0; t < 12; t++) begin
      int nl = $urandom_range(1, 12);
      int base = $urandom_range(0, NPAGES - 1);
      for (int k = 0; k < nl; k++) begin
        int pg = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NPAGES - 1) : base;
        int sl = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 3) : $urandom_range(0, SLOTS - 1);
        strobe(mk(pg, sl), DW'($urandom), 1);
        chk("R10 random last_addr", last_addr, m_la);
        if (k < nl - 1) idle($urandom_range(0, GAP - 2));
      end
      wait_commit();
      check_page("R6 R7 random page", m_page);
      rd_chk("R7 random other", $urandom_range(0, NB - 1));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule